// File: doc/BRIEF.md
# Qualified Protection Latch Controller

This block decides when a switching power converter must shut down for good. It watches two digital comparator outputs. The first is a trip comparator on a dedicated protection input. It is only trusted while the power switch is off, after a settling gap that follows each turn-off, and only if it stays high for a minimum time. Such a qualified event must then recur in four switching cycles in a row. The second is a supply-rail overvoltage comparator, which must stay high for a continuous persistence window.

When either path qualifies, a permanent latch is set. The latch gates the drive request, so no further pulse reaches the switch. The latch is released only when the supply-loss input reports that the holding current has gone away. That same input also wipes all partly collected qualification state. All windows are given in nanoseconds and converted to clock ticks from a tick-rate parameter. The comparators and the supply clamp are outside the block.

Top module: `prot_latch_ctrl`

## Requirements
- R1: After reset `latched` is 0 and `drv_gate` equals `drv_req` combinationally.
- R2: A switching cycle starts on a rising `drv_req` and its off-time starts on the falling one. `trip_cmp` samples taken in the BLANK clock edges that follow the edge which first sees `drv_req` low (125 ticks by default, 1 µs) are ignored, as is the sample on that first edge itself.
- R3: After blanking, and within one off-time, a trip event is recorded only when `trip_cmp` is high on WIDTH consecutive edges (75 by default, 600 ns). A shorter high is discarded and its count restarts. At most one event is recorded per off-time.
- R4: `trip_cmp` is ignored while `drv_req` is high.
- R5: `latched` rises on the clock edge that records the event of the fourth consecutive cycle with an event.
- R6: A cycle that ends, at the next rising `drv_req`, without an event sets the consecutive-cycle count back to zero.
- R7: `rail_ov` high on RAIL consecutive edges (2500 by default, 20 µs) sets `latched` on the RAIL-th edge.
- R8: `rail_ov` low on any edge restarts the rail persistence count from zero.
- R9: While `latched` is 1, `drv_gate` is 0 whatever `drv_req` does, and the latch holds as long as `supply_lost` stays low.
- R10: `supply_lost` high at a clock edge clears `latched` and all trip and rail qualification state at that edge, taking priority over a new qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, tick of all windows |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_lost | input | 1 | Holding current removed; releases latch and clears state |
| drv_req | input | 1 | Drive request from the modulator (1 = switch on) |
| trip_cmp | input | 1 | Protection-input comparator output |
| rail_ov | input | 1 | Supply-rail overvoltage comparator output |
| drv_gate | output | 1 | Drive request gated by the latch |
| latched | output | 1 | Permanent protection latch state |

## Verification
The bench builds the block with its default values: a 125 MHz tick rate, 1000 ns blanking, 600 ns width, 20000 ns rail persistence and four cycles. Those give 125, 75 and 2500 tick windows. At these values every boundary can be placed on an exact edge. The bench uses a 200-sample high that leaves 74 watched samples, a 74 versus 75 sample pulse, the 4th event on the last sample of an off-time, and a rail high of 2499 versus 2500 edges. A full latch sequence through either path still stays within a few thousand cycles.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic [1:0] {
    PH_ON    = 2'd0,
    PH_BLANK = 2'd1,
    PH_WATCH = 2'd2
  } off_phase_e;

  function automatic int ns_to_ticks(input int ns, input int tick_mhz);
    return (ns * tick_mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/plc_offtime_qual.sv
module plc_offtime_qual #(
  parameter int BLANK_TICKS = 125,
  parameter int WIDTH_TICKS = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic drv_req,
  input  logic trip_cmp,
  output logic cyc_start,
  output logic trip_evt
);
  import plc_pkg::*;

  localparam int BW = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
  localparam int HW = (WIDTH_TICKS > 1) ? $clog2(WIDTH_TICKS) : 1;
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_TICKS - 1);
  localparam logic [HW-1:0] HI_LAST    = HW'(WIDTH_TICKS - 1);

  off_phase_e    phase_q, phase_d;
  logic [BW-1:0] blank_q, blank_d;
  logic [HW-1:0] hi_q, hi_d;
  logic          done_q, done_d;
  logic          drv_q;
  logic          fall;

  assign fall      = drv_q & ~drv_req;
  assign cyc_start = drv_req & ~drv_q;
  assign trip_evt  = (phase_q == PH_WATCH) & ~drv_req & trip_cmp &
                     (hi_q == HI_LAST) & ~done_q;

  always_comb begin
    phase_d = phase_q;
    blank_d = blank_q;
    hi_d    = hi_q;
    done_d  = done_q;
    if (clr || drv_req) begin
      phase_d = PH_ON;
      blank_d = '0;
      hi_d    = '0;
      done_d  = 1'b0;
    end else if (fall) begin
      phase_d = PH_BLANK;
      blank_d = '0;
      hi_d    = '0;
      done_d  = 1'b0;
    end else begin
      case (phase_q)
        PH_BLANK: begin
          if (blank_q == BLANK_LAST) phase_d = PH_WATCH;
          else                       blank_d = blank_q + 1'b1;
        end
        PH_WATCH: begin
          if (trip_cmp) begin
            if (hi_q != HI_LAST) hi_d = hi_q + 1'b1;
            if (trip_evt)        done_d = 1'b1;
          end else begin
            hi_d = '0;
          end
        end
        default: phase_d = PH_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ON;
      blank_q <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      blank_q <= blank_d;
      hi_q    <= hi_d;
      done_q  <= done_d;
      drv_q   <= drv_req;
    end
  end

  AST_EVT_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |-> !drv_req); // R4
  AST_EVT_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |-> $past(trip_cmp)); // R3
  AST_EVT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> !trip_evt); // R3

endmodule

// File: rtl/plc_cycle_count.sv
module plc_cycle_count #(
  parameter int TRIP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cyc_start,
  input  logic trip_evt,
  output logic trip_fire
);
  localparam int CW = $clog2(TRIP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TRIP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;

  assign trip_fire = trip_evt & (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (clr) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (cyc_start) begin
      if (!seen_q) cnt_d = '0;
      seen_d = 1'b0;
    end else if (trip_evt) begin
      if (cnt_q != CNT_LAST) cnt_d = cnt_q + 1'b1;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R5
  AST_CNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !seen_q) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/plc_persist_filter.sv
module plc_persist_filter #(
  parameter int PERSIST_TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic level,
  output logic fire
);
  localparam int PW = (PERSIST_TICKS > 1) ? $clog2(PERSIST_TICKS) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PERSIST_TICKS - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign fire = level & ~clr & (cnt_q == P_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !level)       cnt_d = '0;
    else if (cnt_q != P_LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RAIL_HIGH_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(level)); // R7
  AST_RAIL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !level |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/prot_latch_ctrl.sv
module prot_latch_ctrl #(
  parameter int TICK_MHZ    = 125,
  parameter int BLANK_NS    = 1000,
  parameter int WIDTH_NS    = 600,
  parameter int RAIL_NS     = 20000,
  parameter int TRIP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_lost,
  input  logic drv_req,
  input  logic trip_cmp,
  input  logic rail_ov,
  output logic drv_gate,
  output logic latched
);
  import plc_pkg::*;

  localparam int BLANK_TICKS = ns_to_ticks(BLANK_NS, TICK_MHZ);
  localparam int WIDTH_TICKS = ns_to_ticks(WIDTH_NS, TICK_MHZ);
  localparam int RAIL_TICKS  = ns_to_ticks(RAIL_NS, TICK_MHZ);

  logic rst_meta, rst_sync;
  logic cyc_start, trip_evt, trip_fire, rail_fire;
  logic latch_q, latch_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  plc_offtime_qual #(
    .BLANK_TICKS(BLANK_TICKS),
    .WIDTH_TICKS(WIDTH_TICKS)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr      (supply_lost),
    .drv_req  (drv_req),
    .trip_cmp (trip_cmp),
    .cyc_start(cyc_start),
    .trip_evt (trip_evt)
  );

  plc_cycle_count #(
    .TRIP_CYCLES(TRIP_CYCLES)
  ) u_cycles (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr      (supply_lost),
    .cyc_start(cyc_start),
    .trip_evt (trip_evt),
    .trip_fire(trip_fire)
  );

  plc_persist_filter #(
    .PERSIST_TICKS(RAIL_TICKS)
  ) u_rail (
    .clk  (clk),
    .rst_n(rst_sync),
    .clr  (supply_lost),
    .level(rail_ov),
    .fire (rail_fire)
  );

  always_comb begin
    latch_d = latch_q;
    if (supply_lost)                latch_d = 1'b0;
    else if (trip_fire || rail_fire) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) latch_q <= 1'b0;
    else           latch_q <= latch_d;
  end

  assign latched  = latch_q;
  assign drv_gate = drv_req & ~latch_q;

  AST_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(latch_q) |-> $past(trip_fire || rail_fire)); // R5
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync)
    (latch_q && !supply_lost) |=> latch_q); // R9
  AST_RELEASE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_sync)
    $fell(latch_q) |-> $past(supply_lost)); // R10
  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(latch_q) && latch_q |-> !drv_gate); // R9

endmodule

// File: tb/test_prot_latch_ctrl.sv
module test_prot_latch_ctrl;

  logic clk = 1'b0;
  logic rst_n, supply_lost, drv_req, trip_cmp, rail_ov;
  logic drv_gate, latched;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  prot_latch_ctrl i_prot_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_lost(supply_lost), .drv_req(drv_req),
    .trip_cmp(trip_cmp), .rail_ov(rail_ov), .drv_gate(drv_gate),
    .latched(latched)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic on_time(input int n, input logic cmp);
    drv_req  = 1'b1;
    trip_cmp = cmp;
    repeat (n) @(negedge clk);
    trip_cmp = 1'b0;
  endtask

  task automatic off_time(input int len, input int c_start, input int c_len);
    drv_req = 1'b0;
    for (int k = 0; k < len; k++) begin
      trip_cmp = (k >= c_start) && (k < c_start + c_len);
      @(negedge clk);
    end
    trip_cmp = 1'b0;
  endtask

  task automatic good_cycle();
    on_time(20, 1'b0);
    off_time(300, 0, 300);
  endtask

  task automatic release_latch(input string req);
    supply_lost = 1'b1;
    @(negedge clk);
    supply_lost = 1'b0;
    check(req, latched, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 latched after reset", latched, 1'b0);
    drv_req = 1'b1; #1;
    check("R1 gate follows high", drv_gate, 1'b1);
    drv_req = 1'b0; #1;
    check("R1 gate follows low", drv_gate, 1'b0);
  endtask

  task automatic t_on_ignored();
    for (int i = 0; i < 5; i++) begin
      on_time(200, 1'b1);
      off_time(300, 0, 0);
    end
    check("R4 comparator during on-time", latched, 1'b0);
  endtask

  task automatic t_blank();
    for (int i = 0; i < 5; i++) begin
      on_time(20, 1'b0);
      off_time(250, 0, 200);
    end
    check("R2 high inside blanking ignored", latched, 1'b0);
  endtask

  task automatic t_width();
    for (int i = 0; i < 5; i++) begin
      on_time(20, 1'b0);
      off_time(300, 150, 74);
    end
    check("R3 74-tick pulse discarded", latched, 1'b0);
    for (int i = 0; i < 4; i++) begin
      on_time(20, 1'b0);
      off_time(300, 150, 75);
    end
    check("R3 75-tick pulse qualifies", latched, 1'b1);
    release_latch("R10 release after width test");
  endtask

  task automatic t_four();
    for (int i = 0; i < 3; i++) good_cycle();
    check("R5 three cycles not enough", latched, 1'b0);
    on_time(20, 1'b0);
    off_time(201, 0, 201);
    check("R5 latch on fourth event edge", latched, 1'b1);
    drv_req = 1'b1;
    repeat (50) @(negedge clk);
    check("R9 gate blocked while latched", drv_gate, 1'b0);
    check("R9 latch holds", latched, 1'b1);
    release_latch("R10 supply loss releases");
    check("R10 gate follows after release", drv_gate, 1'b1);
    drv_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_count_reset();
    for (int i = 0; i < 3; i++) good_cycle();
    on_time(20, 1'b0);
    off_time(300, 0, 0);
    for (int i = 0; i < 3; i++) good_cycle();
    check("R6 empty cycle resets count", latched, 1'b0);
    good_cycle();
    check("R6 four after reset latch", latched, 1'b1);
    release_latch("R10 release after count test");
  endtask

  task automatic t_clear_state();
    for (int i = 0; i < 3; i++) good_cycle();
    supply_lost = 1'b1;
    @(negedge clk);
    supply_lost = 1'b0;
    good_cycle();
    check("R10 supply loss clears trip count", latched, 1'b0);
    rail_ov = 1'b1;
    repeat (2000) @(negedge clk);
    supply_lost = 1'b1;
    @(negedge clk);
    supply_lost = 1'b0;
    repeat (2000) @(negedge clk);
    check("R10 supply loss clears rail count", latched, 1'b0);
    rail_ov = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) good_cycle();
    supply_lost = 1'b1;
    @(negedge clk);
    supply_lost = 1'b0;
  endtask

  task automatic t_rail();
    rail_ov = 1'b1;
    repeat (2499) @(negedge clk);
    check("R7 rail 2499 ticks short", latched, 1'b0);
    @(negedge clk);
    check("R7 rail 2500 ticks latches", latched, 1'b1);
    rail_ov = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 latch holds after rail drops", latched, 1'b1);
    release_latch("R10 release after rail");
    rail_ov = 1'b1;
    repeat (2000) @(negedge clk);
    rail_ov = 1'b0;
    @(negedge clk);
    rail_ov = 1'b1;
    repeat (2000) @(negedge clk);
    check("R8 dropout restarts filter", latched, 1'b0);
    rail_ov = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; supply_lost = 1'b0; drv_req = 1'b0;
    trip_cmp = 1'b0; rail_ov = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_on_ignored();
    t_blank();
    t_width();
    t_four();
    t_count_reset();
    t_clear_state();
    t_rail();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule